// File: doc/BRIEF.md
# Stopwatch Push-Button Controller

This block sits between four debounced push-buttons and the millisecond digit counters of a stopwatch. It keeps the stopwatch either stopped or running. While running, it passes a one-millisecond tick through to the counters as a count enable. While stopped, it turns each press of the step button into exactly one single-cycle increment pulse, however long the button stays down. A clear button overrides everything else. It emits a single-cycle clear pulse for each press and leaves the stopwatch stopped.

The controller is a three-state machine: stopped and ready for a step, running, and stopped but waiting for the step button to be let go. A tick gate follows it. The gate forwards the millisecond tick only while running. It also refuses any tick that arrives sooner than `MIN_TICK_GAP` clock cycles after the last accepted one, so the count can never advance faster than once per millisecond even if the tick source misbehaves. All outputs are registered. Button levels are sampled on the rising clock edge, and outputs change on that same edge.

Top module: `sw_button_ctrl`

## Requirements
- R1: Reset (`rst` high at a rising edge) drives `run_en`, `inc_pulse`, `clr` and `cnt_en` to 0 after that edge.
- R2: In the ready-stopped state, with `btn_clear` low, a high `btn_start` sets `run_en` to 1 after the edge. When running, `btn_start` is ignored and `run_en` stays 1.
- R3: When running, with `btn_clear` low, a high `btn_stop` clears `run_en` after the edge. When stopped, `btn_stop` is ignored and `run_en` stays 0.
- R4: Each press of `btn_inc` that begins while stopped gives exactly one `inc_pulse`, one cycle wide, whatever the hold time. `inc_pulse` is never high in two consecutive cycles.
- R5: While running, `btn_inc` is ignored: `inc_pulse` stays 0 in the cycle after any cycle with `run_en` high.
- R6: `btn_clear` has priority over all other buttons. After any edge with `btn_clear` high, `run_en`, `inc_pulse` and `cnt_en` are 0.
- R7: The first edge at which `btn_clear` is high (it was low at the previous edge or in reset) sets `clr` for exactly one cycle. Holding `btn_clear` gives no further pulse.
- R8: `cnt_en` rises for one cycle only after an edge where `tick_ms` was 1, `run_en` was 1 and `btn_clear` was 0.
- R9: Two `cnt_en` pulses are at least `MIN_TICK_GAP` cycles apart. A qualifying tick that comes sooner after the last accepted tick is dropped. The first tick after reset is always eligible.
- R10: An increment press that began while running, during clear, or across reset gives no pulse, even if the button is still held once the block is stopped. `inc_pulse` only follows an edge where `btn_inc` was low at the edge before.
- R11: In the ready-stopped state, `btn_start` wins over `btn_inc` at the same edge. The block starts running and no `inc_pulse` is emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_start | input | 1 | Debounced start button level |
| btn_stop | input | 1 | Debounced stop button level |
| btn_inc | input | 1 | Debounced step (increment) button level |
| btn_clear | input | 1 | Debounced clear button level |
| tick_ms | input | 1 | One-cycle pulse once per millisecond |
| run_en | output | 1 | Registered level, 1 while the stopwatch runs |
| inc_pulse | output | 1 | Registered one-cycle step pulse for the counters |
| clr | output | 1 | Registered one-cycle counter clear pulse |
| cnt_en | output | 1 | Registered one-cycle count enable, gated millisecond tick |

## Verification
The bench builds the block with `MIN_TICK_GAP` set to 6. At that value a tick spacing shorter than the guard (3 cycles) and one longer than it (10 cycles) both fit in a few dozen cycles. The drop-and-accept behaviour of R9 is therefore exercised directly next to ordinary running. At the default gap the guard would only show after a hundred thousand cycles. With the small gap, button sequences that hold the step button across stop, clear and reset can each be followed for every cycle against the behavioural model.

// File: rtl/sw_ctl_pkg.sv
package sw_ctl_pkg;

  typedef enum logic [1:0] {
    ST_READY   = 2'd0,
    ST_RUN     = 2'd1,
    ST_WAITREL = 2'd2
  } sw_state_e;

  typedef struct packed {
    sw_state_e nxt;
    logic      step;
  } sw_step_t;

  // Stopped state to land in, given the step button level.
  function automatic sw_state_e settle_stopped(input logic inc_lvl);
    return inc_lvl ? ST_WAITREL : ST_READY;
  endfunction

  // One controller transition. Clear is handled first, then the current state.
  function automatic sw_step_t fsm_step(input sw_state_e cur,
                                        input logic go, input logic halt,
                                        input logic bump, input logic wipe);
    sw_step_t r;
    r.nxt  = cur;
    r.step = 1'b0;
    if (wipe) begin
      r.nxt = settle_stopped(bump);
    end else begin
      case (cur)
        ST_READY: begin
          if (go) begin
            r.nxt = ST_RUN;
          end else if (bump) begin
            r.nxt  = ST_WAITREL;
            r.step = 1'b1;
          end
        end
        ST_RUN: begin
          if (halt) r.nxt = settle_stopped(bump);
        end
        ST_WAITREL: begin
          if (!bump) r.nxt = ST_READY;
        end
        default: r.nxt = ST_READY;
      endcase
    end
    return r;
  endfunction

  // True once a saturating gap counter has reached the limit.
  function automatic logic gap_elapsed(input logic [31:0] gap,
                                       input logic [31:0] limit);
    return gap >= limit;
  endfunction

endpackage

// File: rtl/sw_ctl_fsm.sv
module sw_ctl_fsm
  import sw_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      btn_start,
  input  logic      btn_stop,
  input  logic      btn_inc,
  input  logic      btn_clear,
  output sw_state_e state_q,
  output logic      run_en_q,
  output logic      inc_pulse_q,
  output logic      clr_q,
  output logic      clear_edge
);

  logic     clear_prev_q;
  sw_step_t step_d;

  assign step_d     = fsm_step(state_q, btn_start, btn_stop, btn_inc, btn_clear);
  assign clear_edge = btn_clear & ~clear_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= settle_stopped(btn_inc);
      run_en_q     <= 1'b0;
      inc_pulse_q  <= 1'b0;
      clr_q        <= 1'b0;
      clear_prev_q <= 1'b0;
    end else begin
      state_q      <= step_d.nxt;
      run_en_q     <= (step_d.nxt == ST_RUN);
      inc_pulse_q  <= step_d.step;
      clr_q        <= clear_edge;
      clear_prev_q <= btn_clear;
    end
  end

endmodule

// File: rtl/sw_tick_gate.sv
module sw_tick_gate
  import sw_ctl_pkg::*;
#(
  parameter int MIN_TICK_GAP = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_ms,
  input  logic running,
  input  logic wipe,
  output logic cnt_en_q,
  output logic tick_take
);

  localparam int GW = $clog2(MIN_TICK_GAP + 1);
  localparam logic [GW-1:0] GAP_SAT = GW'(MIN_TICK_GAP);

  logic [GW-1:0] gap_q;
  logic          gap_ok;

  assign gap_ok    = gap_elapsed(32'(gap_q), 32'(MIN_TICK_GAP));
  assign tick_take = tick_ms & running & ~wipe & gap_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q    <= GAP_SAT;
      cnt_en_q <= 1'b0;
    end else begin
      cnt_en_q <= tick_take;
      if (tick_take)          gap_q <= GW'(1);
      else if (!gap_ok)       gap_q <= gap_q + GW'(1);
    end
  end

endmodule

// File: rtl/sw_button_ctrl.sv
module sw_button_ctrl
  import sw_ctl_pkg::*;
#(
  parameter int MIN_TICK_GAP = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_start,
  input  logic btn_stop,
  input  logic btn_inc,
  input  logic btn_clear,
  input  logic tick_ms,
  output logic run_en,
  output logic inc_pulse,
  output logic clr,
  output logic cnt_en
);

  sw_state_e state_q;
  logic      clear_edge;
  logic      tick_take;
  logic      st_ready;

  assign st_ready = (state_q == ST_READY);

  sw_ctl_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .btn_start   (btn_start),
    .btn_stop    (btn_stop),
    .btn_inc     (btn_inc),
    .btn_clear   (btn_clear),
    .state_q     (state_q),
    .run_en_q    (run_en),
    .inc_pulse_q (inc_pulse),
    .clr_q       (clr),
    .clear_edge  (clear_edge)
  );

  sw_tick_gate #(.MIN_TICK_GAP(MIN_TICK_GAP)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .tick_ms   (tick_ms),
    .running   (run_en),
    .wipe      (btn_clear),
    .cnt_en_q  (cnt_en),
    .tick_take (tick_take)
  );

endmodule

// File: rtl/sw_button_ctrl_chk.sv
module sw_button_ctrl_chk #(
  parameter int MIN_TICK_GAP = 100000
) (
  input logic clk,
  input logic rst,
  input logic btn_start,
  input logic btn_stop,
  input logic btn_inc,
  input logic btn_clear,
  input logic tick_ms,
  input logic run_en,
  input logic inc_pulse,
  input logic clr,
  input logic cnt_en,
  input logic st_ready
);

  localparam int GW = $clog2(MIN_TICK_GAP + 1);
  localparam logic [GW-1:0] GAP_SAT = GW'(MIN_TICK_GAP);

  // Cycles since the previous count enable, saturating.
  logic [GW-1:0] since_q;
  always_ff @(posedge clk) begin
    if (rst)               since_q <= GAP_SAT;
    else if (cnt_en)       since_q <= GW'(1);
    else if (since_q < GAP_SAT) since_q <= since_q + GW'(1);
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!run_en && !inc_pulse && !clr && !cnt_en));

  a_r2_start_runs: assert property (@(posedge clk) disable iff (rst)
    (st_ready && btn_start && !btn_clear) |=> run_en);

  a_r3_stop_halts: assert property (@(posedge clk) disable iff (rst)
    (run_en && btn_stop && !btn_clear) |=> !run_en);

  a_r4_inc_single: assert property (@(posedge clk) disable iff (rst)
    inc_pulse |=> !inc_pulse);

  a_r5_no_inc_running: assert property (@(posedge clk) disable iff (rst)
    run_en |=> !inc_pulse);

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
    btn_clear |=> (!run_en && !inc_pulse && !cnt_en));

  a_r7_clr_on_press: assert property (@(posedge clk) disable iff (rst)
    $rose(btn_clear) |=> clr);

  a_r7_clr_one_wide: assert property (@(posedge clk) disable iff (rst)
    clr |=> !clr);

  a_r8_cnt_cause: assert property (@(posedge clk) disable iff (rst)
    cnt_en |-> ($past(run_en) && $past(tick_ms) && !$past(btn_clear)));

  a_r9_min_gap: assert property (@(posedge clk) disable iff (rst)
    cnt_en |-> (since_q >= GAP_SAT));

  a_r10_held_no_pulse: assert property (@(posedge clk) disable iff (rst)
    (btn_inc && $past(btn_inc)) |=> !inc_pulse);

  a_r11_start_beats_inc: assert property (@(posedge clk) disable iff (rst)
    (st_ready && btn_start && btn_inc && !btn_clear) |=> (run_en && !inc_pulse));

endmodule

bind sw_button_ctrl sw_button_ctrl_chk #(.MIN_TICK_GAP(MIN_TICK_GAP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .btn_start (btn_start),
  .btn_stop  (btn_stop),
  .btn_inc   (btn_inc),
  .btn_clear (btn_clear),
  .tick_ms   (tick_ms),
  .run_en    (run_en),
  .inc_pulse (inc_pulse),
  .clr       (clr),
  .cnt_en    (cnt_en),
  .st_ready  (st_ready)
);

// File: tb/tb_sw_button_ctrl.sv
`timescale 1ns/1ps
module tb_sw_button_ctrl;

  localparam int GAP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic b_start = 1'b0, b_stop = 1'b0, b_inc = 1'b0, b_clear = 1'b0, tick = 1'b0;
  logic run_en, inc_pulse, clr, cnt_en;

  int total = 0;
  int bad   = 0;
  int n_inc = 0, n_clr = 0, n_cnt = 0;

  always #2 clk = ~clk;

  sw_button_ctrl #(.MIN_TICK_GAP(GAP)) dut (
    .clk(clk), .rst(rst),
    .btn_start(b_start), .btn_stop(b_stop), .btn_inc(b_inc), .btn_clear(b_clear),
    .tick_ms(tick),
    .run_en(run_en), .inc_pulse(inc_pulse), .clr(clr), .cnt_en(cnt_en)
  );

  // Behavioural reference: mode 0 = stopped and ready, 1 = running,
  // 2 = stopped and waiting for the step button to be released.
  int   mode = 0;
  int   cyc = 0;
  int   last_acc = -1000000;
  logic prev_clear = 1'b0;
  logic e_run = 1'b0, e_inc = 1'b0, e_clr = 1'b0, e_cnt = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      mode = b_inc ? 2 : 0;
      last_acc = -1000000;
      prev_clear = 1'b0;
      e_run = 1'b0; e_inc = 1'b0; e_clr = 1'b0; e_cnt = 1'b0;
      cyc = 0;
    end else begin
      cyc++;
      e_cnt = tick && e_run && !b_clear && (cyc - last_acc >= GAP);
      if (e_cnt) last_acc = cyc;
      e_clr = b_clear && !prev_clear;
      prev_clear = b_clear;
      e_inc = 1'b0;
      if (b_clear)                    mode = b_inc ? 2 : 0;
      else if (mode == 1 && b_stop)   mode = b_inc ? 2 : 0;
      else if (mode == 2 && !b_inc)   mode = 0;
      else if (mode == 0 && b_start)  mode = 1;
      else if (mode == 0 && b_inc) begin
        mode = 2; e_inc = 1'b1;
      end
      e_run = (mode == 1);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2/R3 run_en", int'(run_en), int'(e_run));
      chk("R4/R5 inc_pulse", int'(inc_pulse), int'(e_inc));
      chk("R7 clr", int'(clr), int'(e_clr));
      chk("R8/R9 cnt_en", int'(cnt_en), int'(e_cnt));
      if (inc_pulse) n_inc++;
      if (clr)       n_clr++;
      if (cnt_en)    n_cnt++;
    end
  end

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic zero_counts();
    wait_n(2);
    n_inc = 0; n_clr = 0; n_cnt = 0;
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    chk("R1 reset run_en", int'(run_en), 0);
    chk("R1 reset outputs", int'(inc_pulse | clr | cnt_en), 0);

    // R8: ticks while stopped do nothing; R3: stop while stopped ignored.
    zero_counts();
    pulse_tick(); b_stop = 1'b1; wait_n(2); b_stop = 1'b0; pulse_tick(); wait_n(2);
    chk("R8 no count while stopped", n_cnt, 0);
    chk("R3 stop ignored when stopped", int'(run_en), 0);

    // R4: one long press gives one pulse; a second press gives another.
    zero_counts();
    @(negedge clk); b_inc = 1'b1; wait_n(10); b_inc = 1'b0; wait_n(2);
    b_inc = 1'b1; wait_n(1); b_inc = 1'b0; wait_n(3);
    chk("R4 one pulse per press", n_inc, 2);

    // R11: start and step together -> running, no pulse.
    zero_counts();
    @(negedge clk); b_start = 1'b1; b_inc = 1'b1; @(negedge clk); b_start = 1'b0;
    wait_n(2);
    chk("R11 start wins run_en", int'(run_en), 1);
    chk("R11 start wins no pulse", n_inc, 0);
    // R5/R10: step still held while running, then stop while held.
    wait_n(3);
    @(negedge clk); b_stop = 1'b1; @(negedge clk); b_stop = 1'b0;
    wait_n(4); b_inc = 1'b0; wait_n(3);
    chk("R10 press across stop no pulse", n_inc, 0);
    chk("R3 stop halts", int'(run_en), 0);

    // R2/R8/R9: run with spaced and crowded ticks.
    zero_counts();
    @(negedge clk); b_start = 1'b1; @(negedge clk); b_start = 1'b0;
    wait_n(1);
    chk("R2 start runs", int'(run_en), 1);
    for (int j = 0; j < 4; j++) begin pulse_tick(); wait_n(8); end
    chk("R8 spaced ticks counted", n_cnt, 4);
    n_cnt = 0;
    pulse_tick(); wait_n(1); pulse_tick(); wait_n(8);
    chk("R9 crowded tick dropped", n_cnt, 1);
    // R5: step presses while running ignored; start while running ignored.
    n_inc = 0;
    @(negedge clk); b_inc = 1'b1; b_start = 1'b1; wait_n(2); b_inc = 1'b0; b_start = 1'b0;
    wait_n(2);
    chk("R5 no step while running", n_inc, 0);
    chk("R2 start ignored when running", int'(run_en), 1);

    // R6/R7: clear while running, held, with other buttons.
    zero_counts();
    @(negedge clk); b_clear = 1'b1; tick = 1'b1;
    @(negedge clk); tick = 1'b0; b_start = 1'b1; b_inc = 1'b1;
    wait_n(4); b_start = 1'b0;
    wait_n(1); b_clear = 1'b0;
    wait_n(3);
    chk("R6 clear stops", int'(run_en), 0);
    chk("R6 clear drops tick", n_cnt, 0);
    chk("R7 one clr per press", n_clr, 1);
    b_inc = 1'b0; wait_n(3);
    chk("R10 press during clear no pulse", n_inc, 0);

    // R10: step held across reset gives no pulse.
    zero_counts();
    @(negedge clk); rst = 1'b1; b_inc = 1'b1; wait_n(2); rst = 1'b0;
    wait_n(4); b_inc = 1'b0; wait_n(2);
    chk("R10 press across reset no pulse", n_inc, 0);
    chk("R1 reset leaves stopped", int'(run_en), 0);

    wait_n(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule